// File: doc/BRIEF.md
# Cascaded Long-Timeout Watchdog

This block is a watchdog whose timeout is given in milliseconds as a 32-bit number, yet whose own counter only runs fixed power-of-four intervals from 16 up to 262144 watchdog clocks. On a configure or kick command it turns the millisecond value into a clock count, rounding to the nearest clock. It then covers that count with a chain of intervals, always taking the largest interval that still fits in what is left. The block runs on the watchdog clock itself (`clk`). `CLK_HZ` gives the rate of that clock and is used only for the conversion.

Each interval that is not the last one ends with a one-cycle interrupt and wake-up pulse. The next interval starts on the following clock. Only the last interval is armed to reset the system. When it expires the block gives one last interrupt pulse, then clears its flags and masks its interrupt. The reset output rises a fixed number of clocks later and stays high until software clears it, stops the block, or starts a new chain. A stop command silences the block. A configure command with a zero timeout is refused with a one-cycle error pulse and changes nothing.

Top module: `cascade_wdog`

## Requirements
- R1: A configure command with timeout T ms > 0 stores T and starts a chain over C = floor((T*CLK_HZ + 500) / 1000) clocks. The product is formed at 64 bits.
- R2: Each interval is the largest of 16*4^k clocks (k = 0..7) that is not greater than the remaining count. That interval is taken off the remainder.
- R3: A remainder between 1 and 15 clocks is covered by one final 16-clock interval, and the remainder becomes zero.
- R4: A command that starts a chain takes effect at the clock edge that samples it, with the counter at zero. An interval of L clocks ends L edges later with `irq_o` and `wake_o` high for exactly one cycle. The next interval starts one edge after that.
- R5: `sys_rst_o` rises RST_DELAY (default 3) clock edges after the last interval ends. From then on `flags_o` reads 3'b100. `sys_rst_o` stays high until it is cleared, the block is stopped, or a new chain starts.
- R6: On the edge after the last interval ends, `flags_o` bit 0 (interrupt) and bit 1 (wake-up) are cleared and the interrupt is masked. No further `irq_o` pulse follows.
- R7: A kick command reloads the remainder from the stored timeout and restarts the chain. The timing is as in R4, measured from the kick.
- R8: A configure command with timeout 0 raises `cmd_err_o` for the single cycle after it is sampled. It leaves the stored timeout and the running chain untouched.
- R9: A stop command clears all three flags, masks the interrupt and halts the counter. Afterwards neither `irq_o` nor `sys_rst_o` asserts until a new chain starts.
- R10: With `clr_valid_i` high, each set bit of `clr_mask_i` clears the flag at the same position. Bit 0 is interrupt, bit 1 is wake-up and bit 2 is reset. Clearing bit 2 lowers `sys_rst_o` on the next cycle. Clearing only bits 0 and 1 leaves it high.
- R11: After reset all outputs are low. A kick command before any valid configure has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_op_i | input | 2 | Command: 1 configure, 2 kick, 3 stop, 0 none |
| cmd_ms_i | input | 32 | Timeout in milliseconds for configure |
| clr_valid_i | input | 1 | Flag clear strobe |
| clr_mask_i | input | 3 | Write-one-to-clear mask: bit0 interrupt, bit1 wake-up, bit2 reset |
| irq_o | output | 1 | Interval-end interrupt, interrupt flag and enable |
| wake_o | output | 1 | Wake-up request, wake flag and enable |
| sys_rst_o | output | 1 | System reset request |
| flags_o | output | 3 | Status flags: bit0 interrupt, bit1 wake-up, bit2 reset |
| cmd_err_o | output | 1 | One-cycle pulse when a zero timeout is refused |

## Verification
The assertions assume that commands arrive as single-cycle strobes with a legal operation code. They also assume that no command or flag clear lands between the end of the last interval and the rise of the reset, since such a command would cancel or change the reset in a way the reset-delay property does not model. The stimulus issues each command on its own and then leaves the block alone for the whole chain. Flag clears are applied only once the reset is already high, and the one zero-timeout configure is placed in the middle of an interval. Random timeouts are kept between 1 and 100 ms so that many chains fit within the run, and a directed 600 ms case reaches the 16384-clock interval.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_CFG  = 2'd1,
        OP_KICK = 2'd2,
        OP_STOP = 2'd3
    } wdog_op_e;

    localparam int FLG_INT  = 0;
    localparam int FLG_WAKE = 1;
    localparam int FLG_RST  = 2;
    localparam int FLG_W    = 3;

endpackage

// File: rtl/wdog_ms2clk.sv
module wdog_ms2clk #(
    parameter int CLK_HZ = 10000,
    parameter int MS_W   = 32,
    parameter int REM_W  = 64
) (
    input  logic [MS_W-1:0]  ms_i,
    output logic [REM_W-1:0] clocks_o
);
    localparam int PROD_W = 64;

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quot;

    always_comb begin
        prod     = PROD_W'(ms_i) * PROD_W'(CLK_HZ) + PROD_W'(500);
        quot     = prod / PROD_W'(1000);
        clocks_o = REM_W'(quot);
    end

    always_comb begin
        if (ms_i == '0) begin
            AST_ZERO_MS_ZERO_CLK: assert (clocks_o == '0); // R1
        end
    end

endmodule

// File: rtl/wdog_seg_pick.sv
module wdog_seg_pick #(
    parameter int N_SEG    = 8,
    parameter int BASE_LOG = 4,
    parameter int STEP_LOG = 2,
    parameter int REM_W    = 64,
    parameter int EXP_W    = 5
) (
    input  logic [REM_W-1:0] rem_i,
    output logic             valid_o,
    output logic [EXP_W-1:0] exp_o,
    output logic [REM_W-1:0] rem_next_o,
    output logic             last_o
);
    logic [N_SEG-1:0] fits;

    for (genvar g = 0; g < N_SEG; g++) begin : g_fit
        localparam int LOG_G = BASE_LOG + STEP_LOG * g;
        assign fits[g] = rem_i >= (REM_W'(1) << LOG_G);
    end

    logic [EXP_W-1:0] best_exp;

    always_comb begin
        best_exp = EXP_W'(BASE_LOG);
        for (int i = 0; i < N_SEG; i++) begin
            if (fits[i]) best_exp = EXP_W'(BASE_LOG + STEP_LOG * i);
        end
        valid_o = rem_i != '0;
        exp_o   = best_exp;
        if (fits[0]) rem_next_o = rem_i - (REM_W'(1) << best_exp);
        else         rem_next_o = '0;
        last_o  = rem_next_o == '0;
    end

    always_comb begin
        if (valid_o) begin
            AST_REM_SHRINKS: assert (rem_next_o < rem_i); // R2
            AST_SEG_FITS: assert (!fits[0] || ((REM_W'(1) << exp_o) <= rem_i)); // R2
            AST_SHORT_TAIL: assert (fits[0] || (rem_next_o == '0 && exp_o == EXP_W'(BASE_LOG))); // R3
        end
    end

endmodule

// File: rtl/cascade_wdog.sv
module cascade_wdog
    import wdog_pkg::*;
#(
    parameter int CLK_HZ    = 10000,
    parameter int MS_W      = 32,
    parameter int N_SEG     = 8,
    parameter int BASE_LOG  = 4,
    parameter int STEP_LOG  = 2,
    parameter int RST_DELAY = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid_i,
    input  logic [1:0]      cmd_op_i,
    input  logic [31:0]     cmd_ms_i,
    input  logic            clr_valid_i,
    input  logic [2:0]      clr_mask_i,
    output logic            irq_o,
    output logic            wake_o,
    output logic            sys_rst_o,
    output logic [2:0]      flags_o,
    output logic            cmd_err_o
);
    localparam int REM_W   = 64;
    localparam int MAX_LOG = BASE_LOG + STEP_LOG * (N_SEG - 1);
    localparam int CNT_W   = MAX_LOG;
    localparam int EXP_W   = $clog2(MAX_LOG + 1);
    localparam int DLY_W   = $clog2(RST_DELAY + 1);
    localparam logic [DLY_W-1:0] DLY_FIRST = DLY_W'(RST_DELAY - 1);

    typedef struct packed {
        logic [MS_W-1:0]  ms;
        logic [REM_W-1:0] rem;
        logic [CNT_W-1:0] cnt;
        logic [EXP_W-1:0] exp;
        logic             run;
        logic             last;
        logic             adv;
        logic             dpend;
        logic [DLY_W-1:0] dly;
        logic             int_en;
        logic             wake_en;
        logic             fint;
        logic             fwake;
        logic             frst;
        logic             err;
    } wdog_state_t;

    wdog_state_t st_q, st_d;

    // command decode, from inputs and registered state only
    logic [MS_W-1:0]  ms_w;
    logic             cmd_cfg, cmd_kick, cmd_stop, cmd_bad, cmd_start;
    logic [MS_W-1:0]  conv_in;
    logic [REM_W-1:0] conv_clk;
    logic [REM_W-1:0] sel_in;
    logic             sel_valid, sel_last;
    logic [EXP_W-1:0] sel_exp;
    logic [REM_W-1:0] sel_rem;

    assign ms_w      = MS_W'(cmd_ms_i);
    assign cmd_cfg   = cmd_valid_i && (cmd_op_i == OP_CFG);
    assign cmd_kick  = cmd_valid_i && (cmd_op_i == OP_KICK);
    assign cmd_stop  = cmd_valid_i && (cmd_op_i == OP_STOP);
    assign cmd_bad   = cmd_cfg && (ms_w == '0);
    assign cmd_start = (cmd_cfg && !cmd_bad) || (cmd_kick && st_q.ms != '0);
    assign conv_in   = cmd_cfg ? ms_w : st_q.ms;
    assign sel_in    = cmd_start ? conv_clk : st_q.rem;

    wdog_ms2clk #(
        .CLK_HZ (CLK_HZ),
        .MS_W   (MS_W),
        .REM_W  (REM_W)
    ) i_conv (
        .ms_i     (conv_in),
        .clocks_o (conv_clk)
    );

    wdog_seg_pick #(
        .N_SEG    (N_SEG),
        .BASE_LOG (BASE_LOG),
        .STEP_LOG (STEP_LOG),
        .REM_W    (REM_W),
        .EXP_W    (EXP_W)
    ) i_pick (
        .rem_i      (sel_in),
        .valid_o    (sel_valid),
        .exp_o      (sel_exp),
        .rem_next_o (sel_rem),
        .last_o     (sel_last)
    );

    logic [CNT_W:0] seg_len;
    logic           seg_end;

    assign seg_len = (CNT_W+1)'(1) << st_q.exp;
    assign seg_end = st_q.run && ({1'b0, st_q.cnt} == seg_len - (CNT_W+1)'(1));

    always_comb begin
        logic do_start;

        st_d     = st_q;
        st_d.err = 1'b0;
        do_start = 1'b0;

        // write-one-to-clear flags
        if (clr_valid_i) begin
            if (clr_mask_i[FLG_INT])  st_d.fint  = 1'b0;
            if (clr_mask_i[FLG_WAKE]) st_d.fwake = 1'b0;
            if (clr_mask_i[FLG_RST])  st_d.frst  = 1'b0;
        end

        // interval counter
        if (st_q.run) begin
            if (seg_end) begin
                st_d.cnt   = '0;
                st_d.run   = 1'b0;
                st_d.fint  = 1'b1;
                st_d.fwake = 1'b1;
                if (st_q.last) begin
                    st_d.dpend = 1'b1;
                    st_d.dly   = DLY_FIRST;
                end else begin
                    st_d.adv = 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end

        // chain the next interval one cycle after the previous one ends
        if (st_q.adv) begin
            st_d.adv = 1'b0;
            do_start = 1'b1;
        end

        // final interval expired: quiet the interrupt, then count to reset
        if (st_q.dpend) begin
            if (st_q.dly == DLY_FIRST) begin
                st_d.fint   = 1'b0;
                st_d.fwake  = 1'b0;
                st_d.frst   = 1'b0;
                st_d.int_en = 1'b0;
            end
            if (st_q.dly == '0) begin
                st_d.frst  = 1'b1;
                st_d.dpend = 1'b0;
            end else begin
                st_d.dly = st_q.dly - DLY_W'(1);
            end
        end

        // commands take priority over internal progress
        if (cmd_bad) begin
            st_d.err = 1'b1;
        end
        if (cmd_cfg && !cmd_bad) begin
            st_d.ms = ms_w;
        end
        if (cmd_start) begin
            do_start = 1'b1;
        end
        if (cmd_stop) begin
            do_start     = 1'b0;
            st_d.fint    = 1'b0;
            st_d.fwake   = 1'b0;
            st_d.frst    = 1'b0;
            st_d.int_en  = 1'b0;
            st_d.run     = 1'b0;
            st_d.adv     = 1'b0;
            st_d.dpend   = 1'b0;
            st_d.cnt     = '0;
        end

        if (do_start) begin
            if (sel_valid) begin
                st_d.exp     = sel_exp;
                st_d.rem     = sel_rem;
                st_d.last    = sel_last;
                st_d.cnt     = '0;
                st_d.run     = 1'b1;
                st_d.adv     = 1'b0;
                st_d.dpend   = 1'b0;
                st_d.dly     = '0;
                st_d.int_en  = 1'b1;
                st_d.wake_en = 1'b1;
                st_d.fint    = 1'b0;
                st_d.fwake   = 1'b0;
                st_d.frst    = 1'b0;
            end else begin
                st_d.run = 1'b0;
                st_d.adv = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o     = st_q.fint && st_q.int_en;
    assign wake_o    = st_q.fwake && st_q.wake_en;
    assign sys_rst_o = st_q.frst;
    assign flags_o   = {st_q.frst, st_q.fwake, st_q.fint};
    assign cmd_err_o = st_q.err;

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o); // R4

    AST_RST_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) && !$past(clr_valid_i) |-> $past(irq_o, RST_DELAY)); // R5

    AST_QUIET_BEFORE_RST: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.dpend && (st_q.dly != DLY_FIRST) |-> !irq_o && !wake_o); // R6

    AST_BAD_CFG_KEEPS_MS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_bad |=> cmd_err_o && $stable(st_q.ms)); // R8

    AST_STOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stop |=> !irq_o && !sys_rst_o && !st_q.run); // R9

    AST_CLR_RST: assert property (@(posedge clk) disable iff (!rst_n)
        clr_valid_i && clr_mask_i[FLG_RST] && !cmd_start && !(st_q.dpend && st_q.dly == '0)
        |=> !sys_rst_o); // R10

endmodule

// File: tb/test_cascade_wdog.sv
module test_cascade_wdog;

    localparam int HZ = 32768;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid_i = 1'b0;
    logic [1:0]  cmd_op_i = 2'd0;
    logic [31:0] cmd_ms_i = '0;
    logic        clr_valid_i = 1'b0;
    logic [2:0]  clr_mask_i = '0;
    logic        irq_o, wake_o, sys_rst_o, cmd_err_o;
    logic [2:0]  flags_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    cascade_wdog #(.CLK_HZ(HZ)) i_cascade_wdog (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid_i (cmd_valid_i),
        .cmd_op_i    (cmd_op_i),
        .cmd_ms_i    (cmd_ms_i),
        .clr_valid_i (clr_valid_i),
        .clr_mask_i  (clr_mask_i),
        .irq_o       (irq_o),
        .wake_o      (wake_o),
        .sys_rst_o   (sys_rst_o),
        .flags_o     (flags_o),
        .cmd_err_o   (cmd_err_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint ms2clk(input longint ms);
        return (ms * HZ + 500) / 1000;
    endfunction

    // send one command; returns at the sample point right after it took effect
    task automatic send(input logic [1:0] op, input logic [31:0] ms);
        @(negedge clk);
        cmd_valid_i = 1'b1;
        cmd_op_i    = op;
        cmd_ms_i    = ms;
        @(negedge clk);
        cmd_valid_i = 1'b0;
        cmd_op_i    = 2'd0;
    endtask

    // follow a whole chain from k=0 (state just after the starting edge)
    task automatic watch(input longint ms, input int bad_k, input string tag);
        longint rem, len;
        longint tend [64];
        int     n = 0;
        longint t = 0;
        int irq_bad = 0, rst_bad = 0, wake_bad = 0;
        rem = ms2clk(ms);
        while (rem != 0 && n < 64) begin
            len = 16;
            for (int j = 7; j >= 0; j--) begin
                if (rem >= (longint'(16) << (2 * j))) begin
                    len = longint'(16) << (2 * j);
                    break;
                end
            end
            if (rem < 16) rem = 0;
            else          rem = rem - len;
            t = (n == 0) ? len : t + 1 + len;
            tend[n] = t;
            n++;
        end
        for (longint k = 0; k <= t + 6; k++) begin
            bit hit = 0;
            for (int i = 0; i < n; i++) if (tend[i] == k) hit = 1;
            if (irq_o !== hit) irq_bad++;
            if (wake_o !== hit) wake_bad++;
            if (sys_rst_o !== (k >= t + 3)) rst_bad++;
            if (k == t + 1) chk(flags_o == 3'b000 && !irq_o, {tag, " R6 flags after final"}, flags_o, 0);
            if (k == t + 3) chk(flags_o == 3'b100, {tag, " R5 flags at reset"}, flags_o, 4);
            if (bad_k >= 0 && k == bad_k) begin
                cmd_valid_i = 1'b1; cmd_op_i = 2'd1; cmd_ms_i = 0;
            end
            if (bad_k >= 0 && k == bad_k + 1) begin
                chk(cmd_err_o == 1'b1, {tag, " R8 err pulse"}, cmd_err_o, 1);
            end
            if (bad_k >= 0 && k == bad_k + 2) begin
                chk(cmd_err_o == 1'b0, {tag, " R8 err one cycle"}, cmd_err_o, 0);
            end
            @(negedge clk);
            if (bad_k >= 0 && k == bad_k) begin
                cmd_valid_i = 1'b0; cmd_op_i = 2'd0;
            end
        end
        chk(irq_bad == 0, {tag, " R2 R4 irq timing"}, irq_bad, 0);
        chk(wake_bad == 0, {tag, " R4 wake timing"}, wake_bad, 0);
        chk(rst_bad == 0, {tag, " R5 reset timing"}, rst_bad, 0);
    endtask

    task automatic quiet(input int cycles, input string tag);
        int bad = 0;
        for (int k = 0; k < cycles; k++) begin
            if (irq_o || sys_rst_o || wake_o) bad++;
            @(negedge clk);
        end
        chk(bad == 0, tag, bad, 0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk({irq_o, wake_o, sys_rst_o, flags_o, cmd_err_o} == '0, "R11 reset outputs", flags_o, 0);
        send(2'd2, 0);
        quiet(100, "R11 kick before configure ignored");

        // R1 R3: 1 ms -> 33 clocks -> 16,16,16
        send(2'd1, 1);
        watch(1, -1, "R1 R3 1ms");

        // R10 W1C of reset flag
        @(negedge clk);
        chk(sys_rst_o == 1'b1, "R5 reset held", sys_rst_o, 1);
        clr_valid_i = 1'b1; clr_mask_i = 3'b011;
        @(negedge clk);
        clr_valid_i = 1'b0;
        chk(sys_rst_o == 1'b1, "R10 clear of other bits keeps reset", sys_rst_o, 1);
        clr_valid_i = 1'b1; clr_mask_i = 3'b100;
        @(negedge clk);
        clr_valid_i = 1'b0;
        chk(sys_rst_o == 1'b0 && flags_o == 3'b000, "R10 reset flag cleared", flags_o, 0);

        // R8 zero configure mid-chain
        send(2'd1, 3);
        watch(3, 30, "R8 3ms");

        // R7 kick restarts
        send(2'd1, 5);
        repeat (100) @(negedge clk);
        send(2'd2, 0);
        watch(5, -1, "R7 kick 5ms");

        // R9 stop
        send(2'd1, 2);
        repeat (40) @(negedge clk);
        send(2'd3, 0);
        chk(flags_o == 3'b000, "R9 flags after stop", flags_o, 0);
        quiet(300, "R9 silent after stop");

        // R2 large chain reaching 16384
        send(2'd1, 600);
        watch(600, -1, "R2 600ms");

        // random timeouts
        for (int r = 0; r < 10; r++) begin
            int ms;
            ms = $urandom_range(100, 1);
            send(2'd1, ms);
            watch(ms, -1, $sformatf("R4 rand %0dms", ms));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule